// File: doc/BRIEF.md
# BCD Year Counter with Leap Detection

This block holds the year portion of a real-time clock calendar as packed BCD digits. The default build holds two digits, the last two decimal digits of the year, in the range 00 to 99. Each single-cycle carry pulse from the month stage advances the year by one while the clock is running. Advancing past the all-nines value wraps to zero. A leap-year flag is decoded from the two least significant BCD digits without any binary conversion. The day/month logic uses this flag to set the length of February.

Software loads the register through a plain write strobe with write data. A load is accepted only while the run control is low, which means counting is halted. A write made while running is dropped. The count register has no reset. Neither the system reset nor any low-power entry clears it, and carries keep counting while reset is asserted. The reset pin reaches only the bound checks.

The interface is a control/status register interface, not a data stream, so it has no valid/ready handshake. A write is taken on the clock edge where its strobe is sampled. No back-pressure exists: a write that is dropped because the block is running gives no indication and must not be retried while running.

Top module: `bcd_year_counter`

## Requirements
- R1: `year[7:4]` holds the tens BCD digit and `year[3:0]` holds the units BCD digit. In wider builds, each further digit takes the next higher 4 bits.
- R2: When `wr_en` is 1 and `run` is 0 at a clock edge, `year` equals `wr_data` after that edge.
- R3: When `run` is 1, `wr_en` has no effect on `year`.
- R4: When `run` is 1 and `yr_carry` is 1 at a clock edge, `year` increases by one in BCD after that edge. A units digit of 9 becomes 0 and carries into the tens digit.
- R5: An increment from the all-nines value (99 in the default build) yields all zeros.
- R6: When `run` is 0, `yr_carry` is ignored and `year` holds. A simultaneous write still loads `wr_data`.
- R7: `leap` is 1 exactly when the value of the two lowest digits is divisible by 4, with 00 counted as leap. The flag is combinational from `year`.
- R8: Asserting `rst_n` low neither changes nor clears `year`, and carries received while reset is low are still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low system reset; the count ignores it, only the checks use it |
| run | input | 1 | 1 = counting enabled and writes blocked; 0 = halted and writable |
| wr_en | input | 1 | Write strobe for one clock |
| wr_data | input | 4*NDIG | Packed BCD value to load |
| yr_carry | input | 1 | One-cycle year carry from the month stage |
| year | output | 4*NDIG | Packed BCD year count |
| leap | output | 1 | Leap-year flag |

## Verification
The bench builds the default two-digit counter and a second instance with NDIG set to 3, and both share the control pins. The two-digit build reaches the 99-to-00 wrap and every value of the leap decode. The three-digit build reaches the ripple of a carry through two cascaded digits at 999. It also shows that the leap flag depends only on the two lowest digits when a hundreds digit is present.

// File: rtl/yr_pkg.sv
package yr_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;
  typedef logic [DIG_W-1:0] bcd_t;
endpackage

// File: rtl/bcd_digit_step.sv
module bcd_digit_step
  import yr_pkg::*;
(
  input  bcd_t cur,
  input  logic inc,
  output bcd_t nxt,
  output logic co
);
  logic at_max;
  assign at_max = (cur == DIG_MAX);
  assign co     = inc & at_max;

  always_comb begin
    if (!inc)        nxt = cur;
    else if (at_max) nxt = '0;
    else             nxt = cur + bcd_t'(1);
  end
endmodule

// File: rtl/bcd_leap_decode.sv
module bcd_leap_decode
  import yr_pkg::*;
(
  input  bcd_t tens,
  input  bcd_t units,
  output logic leap
);
  logic tens_odd;
  logic u_even_set;
  logic u_odd_set;

  assign tens_odd   = tens[0];
  assign u_even_set = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
  assign u_odd_set  = (units == 4'd2) || (units == 4'd6);
  assign leap       = tens_odd ? u_odd_set : u_even_set;
endmodule

// File: rtl/bcd_year_counter.sv
module bcd_year_counter
  import yr_pkg::*;
#(
  parameter  int NDIG = 2,
  localparam int W    = NDIG * DIG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         yr_carry,
  output logic [W-1:0] year,
  output logic         leap
);
  logic [W-1:0] year_q;
  logic [W-1:0] year_inc;
  logic [NDIG:0] chain;
  logic load;
  logic step;

  assign load = wr_en & ~run;
  assign step = yr_carry & run;

  assign chain[0] = 1'b1;
  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    bcd_digit_step u_step (
      .cur (year_q[g*DIG_W +: DIG_W]),
      .inc (chain[g]),
      .nxt (year_inc[g*DIG_W +: DIG_W]),
      .co  (chain[g+1])
    );
  end

  // No reset by intent: the count survives every reset and low-power entry.
  always_ff @(posedge clk) begin
    if (load)      year_q <= wr_data;
    else if (step) year_q <= year_inc;
  end

  bcd_leap_decode u_leap (
    .tens  (year_q[2*DIG_W-1:DIG_W]),
    .units (year_q[DIG_W-1:0]),
    .leap  (leap)
  );

  assign year = year_q;
endmodule

// File: rtl/year_ctr_chk.sv
module year_ctr_chk #(
  parameter  int NDIG = 2,
  localparam int W    = NDIG * 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         yr_carry,
  input logic [W-1:0] year,
  input logic         leap
);
  logic known;
  int   low2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              known <= 1'b0;
    else if (wr_en && !run)  known <= 1'b1;
  end

  assign low2 = int'(year[7:4]) * 10 + int'(year[3:0]);

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !run) |=> (year == $past(wr_data))); // R2

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n || !known)
    (run && wr_en && !yr_carry) |=> $stable(year)); // R3

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !known)
    (run && yr_carry && (year == {NDIG{4'h9}})) |=> (year == '0)); // R5

  AST_HALTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !known)
    (!run && !wr_en) |=> $stable(year)); // R6

  AST_LEAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n || !known)
    leap == ((low2 % 4) == 0)); // R7
endmodule

bind bcd_year_counter year_ctr_chk #(.NDIG(NDIG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .yr_carry (yr_carry),
  .year     (year),
  .leap     (leap)
);

// File: tb/sim_bcd_year_counter.sv
`timescale 1ns/1ps
module sim_bcd_year_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic wr_en = 1'b0;
  logic yr_carry = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [11:0] wr_data1 = '0;
  logic [7:0]  year;
  logic [11:0] year1;
  logic leap, leap1;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  bcd_year_counter #(.NDIG(2)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_data(wr_data),
    .yr_carry(yr_carry), .year(year), .leap(leap));

  bcd_year_counter #(.NDIG(3)) u1 (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_data(wr_data1),
    .yr_carry(yr_carry), .year(year1), .leap(leap1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic [11:0] d1);
    @(negedge clk);
    run = 1'b0; wr_en = 1'b1; wr_data = d; wr_data1 = d1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_carry();
    @(negedge clk);
    yr_carry = 1'b1;
    @(negedge clk);
    yr_carry = 1'b0;
  endtask

  task automatic t_load();
    do_write(8'h45, 12'h045);
    chk(year == 8'h45, "R2", year, 8'h45);
    chk(year[7:4] == 4'd4 && year[3:0] == 4'd5, "R1", year, 8'h45);
    chk(year1 == 12'h045, "R1", year1, 12'h045);
  endtask

  task automatic t_busy_write();
    do_write(8'h30, 12'h130);
    @(negedge clk); run = 1'b1; wr_en = 1'b1; wr_data = 8'h11; wr_data1 = 12'h111;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    chk(year == 8'h30, "R3", year, 8'h30);
    chk(year1 == 12'h130, "R3", year1, 12'h130);
    run = 1'b0;
  endtask

  task automatic t_increment();
    do_write(8'h18, 12'h018);
    run = 1'b1;
    pulse_carry();
    chk(year == 8'h19, "R4", year, 8'h19);
    pulse_carry();
    chk(year == 8'h20, "R4", year, 8'h20);
    @(negedge clk); yr_carry = 1'b1;
    @(negedge clk);
    chk(year == 8'h21, "R4", year, 8'h21);
    @(negedge clk); yr_carry = 1'b0;
    chk(year == 8'h22, "R4", year, 8'h22);
    run = 1'b0;
  endtask

  task automatic t_wrap();
    do_write(8'h98, 12'h998);
    run = 1'b1;
    pulse_carry();
    chk(year == 8'h99, "R5", year, 8'h99);
    chk(year1 == 12'h999, "R5", year1, 12'h999);
    pulse_carry();
    chk(year == 8'h00, "R5", year, 8'h00);
    chk(year1 == 12'h000, "R5", year1, 12'h000);
    chk(leap == 1'b1, "R7", leap, 1);
    run = 1'b0;
  endtask

  task automatic t_halted();
    do_write(8'h57, 12'h057);
    pulse_carry();
    chk(year == 8'h57, "R6", year, 8'h57);
    @(negedge clk); yr_carry = 1'b1; wr_en = 1'b1; wr_data = 8'h63; wr_data1 = 12'h063;
    @(negedge clk); yr_carry = 1'b0; wr_en = 1'b0;
    chk(year == 8'h63, "R6", year, 8'h63);
    repeat (3) @(negedge clk);
    chk(year == 8'h63, "R6", year, 8'h63);
  endtask

  task automatic t_leap();
    for (int v = 0; v < 100; v++) begin
      logic [7:0] b;
      b = {4'(v / 10), 4'(v % 10)};
      do_write(b, {4'd1, b});
      chk(leap == ((v % 4) == 0), "R7", leap, int'((v % 4) == 0));
      chk(leap1 == ((v % 4) == 0), "R7", leap1, int'((v % 4) == 0));
    end
  endtask

  task automatic t_reset();
    do_write(8'h37, 12'h237);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(year == 8'h37, "R8", year, 8'h37);
    run = 1'b1;
    pulse_carry();
    chk(year == 8'h38, "R8", year, 8'h38);
    chk(year1 == 12'h238, "R8", year1, 12'h238);
    @(negedge clk); rst_n = 1'b1; run = 1'b0;
    @(negedge clk);
    chk(year == 8'h38, "R8", year, 8'h38);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_load();
    t_busy_write();
    t_increment();
    t_wrap();
    t_halted();
    t_leap();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule